// File: doc/BRIEF.md
# Predicated Vector Expand Unit

This block spreads the low elements of one vector register value across the active lanes of a predicate. It visits destination lanes from lane 0 upward. Each active lane takes the next source element that has not yet been used, starting from source element 0. Every inactive lane is written with zero. The element width is chosen at run time from a 2-bit code, so one predicate with one bit per vector byte serves byte, halfword, word and doubleword operation.

The unit also decodes the 32-bit instruction word that carries the operation. It checks the fixed opcode bits and extracts the element-size code and the predicate, source and destination register indices. The predicate and source indices are presented combinationally, so the caller can fetch operands in the same cycle as the instruction. The instruction is flagged undefined when its opcode does not match. It is also flagged undefined when it is issued in the restricted streaming mode and the enabling capability input is low. The result is registered and appears one cycle after the input strobe, together with the destination register index.

Top module: `vec_expand_unit`

## Requirements
- R1: The element width in bytes is 1 shifted left by the size code taken from instruction bits 23:22 (code 0 gives 1 byte, 1 gives 2, 2 gives 4, 3 gives 8), and a vector of `VLEN` bits holds `VLEN/8` bytes.
- R2: Lane `l` of an element `E` bytes wide is active exactly when predicate bit `l*E` is set; the other predicate bits of that lane have no effect on the result.
- R3: Active lanes, taken in increasing lane order, receive source elements 0, 1, 2 and onward in turn. The source element index advances only on active lanes.
- R4: Every inactive lane of the result is zero, so a predicate with no active lane yields an all-zero result.
- R5: The instruction is recognised only when bits 31:24 equal 8'h05 and bits 21:13 equal 9'b110001100. Any other word raises `res_undef`.
- R6: When `streaming_mode` is high and `stream_cap_en` is low, a recognised instruction raises `res_undef`. When either condition is absent, the instruction is legal.
- R7: For an undefined instruction, `res_valid` stays low and `res_data` and `res_dst` are zero.
- R8: A legal instruction accepted on `in_valid` gives `res_valid` high on the next cycle. `res_dst` then holds bits 4:0 of that instruction. `dec_pg` (bits 12:10) and `dec_zn` (bits 9:5) follow the instruction word combinationally.
- R9: After a synchronous reset, `res_valid` and `res_undef` are low and `res_data` and `res_dst` are zero.
- R10: In a cycle after `in_valid` was low, `res_valid` and `res_undef` are low, and `res_data` and `res_dst` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| insn | input | 32 | Instruction word |
| streaming_mode | input | 1 | Issued in the restricted streaming mode |
| stream_cap_en | input | 1 | Capability that permits the operation in streaming mode |
| src_vec | input | VLEN | Source vector value |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| dec_pg | output | 3 | Predicate register index from the instruction |
| dec_zn | output | 5 | Source register index from the instruction |
| res_valid | output | 1 | Registered result is valid |
| res_undef | output | 1 | Registered instruction was undefined |
| res_dst | output | 5 | Destination register index for the result |
| res_data | output | VLEN | Expanded result |

## Verification
The bench builds the unit with the default `VLEN` of 256. This gives 32 predicate bits, so doubleword operation has four lanes and byte operation has thirty-two. At this length, random predicates reach both densely and sparsely populated lanes for every size code. Directed cases drive an empty predicate, a full predicate and a predicate that sets only the bits a wider element must ignore. They also drive corrupted opcode fields and all four combinations of the mode and capability inputs.

// File: rtl/vexp_pkg.sv
package vexp_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_HALF  = 2'd1,
        ESZ_WORD  = 2'd2,
        ESZ_DWORD = 2'd3
    } esz_e;

    localparam logic [7:0] OPC_TOP = 8'h05;
    localparam logic [8:0] OPC_MID = 9'b110001100;

    typedef struct packed {
        logic       match;
        esz_e       size;
        logic [2:0] pg;
        logic [4:0] zn;
        logic [4:0] zd;
    } dec_t;

    function automatic logic [3:0] elem_bytes(esz_e s);
        return 4'd1 << s;
    endfunction

endpackage

// File: rtl/vexp_decode.sv
module vexp_decode
    import vexp_pkg::*;
(
    input  logic [31:0] insn,
    input  logic        streaming_mode,
    input  logic        stream_cap_en,
    output dec_t        dec,
    output logic        undef
);

    logic mode_block;

    always_comb begin
        dec.match  = (insn[31:24] == OPC_TOP) && (insn[21:13] == OPC_MID);
        dec.size   = esz_e'(insn[23:22]);
        dec.pg     = insn[12:10];
        dec.zn     = insn[9:5];
        dec.zd     = insn[4:0];
        mode_block = streaming_mode && !stream_cap_en;
        undef      = !dec.match || mode_block;
    end

endmodule

// File: rtl/vexp_lane_map.sv
module vexp_lane_map
    import vexp_pkg::*;
#(
    parameter int NB = 32,
    localparam int IW = $clog2(NB),
    localparam int CW = IW + 1
) (
    input  logic [NB-1:0]         pred,
    input  esz_e                  size,
    output logic [NB-1:0]         byte_act,
    output logic [NB-1:0][IW-1:0] byte_sel
);

    always_comb begin
        logic [CW-1:0] run_idx;
        logic [IW-1:0] base;
        logic [IW-1:0] off;
        logic [IW-1:0] off_mask;
        logic          lane_on;
        run_idx  = '0;
        base     = '0;
        lane_on  = 1'b0;
        off_mask = IW'(elem_bytes(size) - 4'd1);
        for (int b = 0; b < NB; b++) begin
            off = IW'(b) & off_mask;
            if (off == '0) begin
                lane_on = pred[b];
                base    = IW'(run_idx << size);
                if (lane_on) begin
                    run_idx = run_idx + 1'b1;
                end
            end
            byte_act[b] = lane_on;
            byte_sel[b] = base | off;
        end
    end

    // A byte never draws from a source byte above its own position.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            if (!$isunknown(byte_sel[b])) begin
                // R3
                sel_not_ahead_chk: assert (byte_sel[b] <= IW'(b));
            end
        end
    end

endmodule

// File: rtl/vexp_xbar.sv
module vexp_xbar #(
    parameter int NB = 32,
    localparam int IW = $clog2(NB)
) (
    input  logic [NB*8-1:0]       src,
    input  logic [NB-1:0]         byte_act,
    input  logic [NB-1:0][IW-1:0] byte_sel,
    output logic [NB*8-1:0]       dout
);

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign dout[b*8 +: 8] = byte_act[b] ? src[byte_sel[b]*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/vec_expand_unit.sv
module vec_expand_unit
    import vexp_pkg::*;
#(
    parameter int VLEN = 256,
    localparam int NB = VLEN / 8,
    localparam int IW = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic            streaming_mode,
    input  logic            stream_cap_en,
    input  logic [VLEN-1:0] src_vec,
    input  logic [NB-1:0]   pred,
    output logic [2:0]      dec_pg,
    output logic [4:0]      dec_zn,
    output logic            res_valid,
    output logic            res_undef,
    output logic [4:0]      res_dst,
    output logic [VLEN-1:0] res_data
);

    if ((VLEN % 128 != 0) || (VLEN < 128) || (VLEN > 2048)) begin : g_bad_vlen
        $error("VLEN must be a multiple of 128 from 128 to 2048");
    end

    dec_t                  dec;
    logic                  undef;
    logic [NB-1:0]         byte_act;
    logic [NB-1:0][IW-1:0] byte_sel;
    logic [VLEN-1:0]       expanded;

    vexp_decode u_dec (
        .insn           (insn),
        .streaming_mode (streaming_mode),
        .stream_cap_en  (stream_cap_en),
        .dec            (dec),
        .undef          (undef)
    );

    vexp_lane_map #(.NB(NB)) u_map (
        .pred     (pred),
        .size     (dec.size),
        .byte_act (byte_act),
        .byte_sel (byte_sel)
    );

    vexp_xbar #(.NB(NB)) u_xbar (
        .src      (src_vec),
        .byte_act (byte_act),
        .byte_sel (byte_sel),
        .dout     (expanded)
    );

    assign dec_pg = dec.pg;
    assign dec_zn = dec.zn;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_undef <= 1'b0;
            res_dst   <= '0;
            res_data  <= '0;
        end else if (in_valid) begin
            res_valid <= !undef;
            res_undef <= undef;
            res_dst   <= undef ? 5'd0 : dec.zd;
            res_data  <= undef ? '0 : expanded;
        end else begin
            res_valid <= 1'b0;
            res_undef <= 1'b0;
        end
    end

    // R7
    valid_undef_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && res_undef));

    // R7
    undef_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        res_undef |-> (res_data == '0 && res_dst == 5'd0));

    // R8
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid));

    // R10
    idle_holds_data_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && !res_undef && $stable(res_data)));

    // R6
    stream_block_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && streaming_mode && !stream_cap_en) |=> res_undef);

endmodule

// File: tb/tb_vec_expand_unit.sv
`timescale 1ns/1ps
module tb_vec_expand_unit;

    localparam int VLEN = 256;
    localparam int NB   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [31:0]     insn;
    logic            streaming_mode;
    logic            stream_cap_en;
    logic [VLEN-1:0] src_vec;
    logic [NB-1:0]   pred;
    logic [2:0]      dec_pg;
    logic [4:0]      dec_zn;
    logic            res_valid;
    logic            res_undef;
    logic [4:0]      res_dst;
    logic [VLEN-1:0] res_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    vec_expand_unit #(.VLEN(VLEN)) dut (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .insn           (insn),
        .streaming_mode (streaming_mode),
        .stream_cap_en  (stream_cap_en),
        .src_vec        (src_vec),
        .pred           (pred),
        .dec_pg         (dec_pg),
        .dec_zn         (dec_zn),
        .res_valid      (res_valid),
        .res_undef      (res_undef),
        .res_dst        (res_dst),
        .res_data       (res_data)
    );

    function automatic logic [31:0] mk_insn(logic [1:0] sz, logic [2:0] pg,
                                            logic [4:0] zn, logic [4:0] zd);
        return {8'h05, sz, 9'b110001100, pg, zn, zd};
    endfunction

    // Element-by-element reference of the expand rule.
    function automatic logic [VLEN-1:0] ref_expand(logic [VLEN-1:0] s,
                                                   logic [NB-1:0] p, logic [1:0] sz);
        logic [VLEN-1:0] r;
        int eb, nel, x;
        r   = '0;
        eb  = 1 << sz;
        nel = NB / eb;
        x   = 0;
        for (int e = 0; e < nel; e++) begin
            if (p[e*eb]) begin
                for (int k = 0; k < eb; k++)
                    r[(e*eb+k)*8 +: 8] = s[(x*eb+k)*8 +: 8];
                x++;
            end
        end
        return r;
    endfunction

    task automatic check_bit(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_vec(string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    logic [VLEN-1:0] last_data;
    logic [4:0]      last_dst;

    task automatic run_vec(string tag, logic [31:0] w, logic strm, logic cap,
                           logic [VLEN-1:0] s, logic [NB-1:0] p);
        logic ok;
        logic [VLEN-1:0] exp_d;
        logic [4:0] exp_dst;
        @(negedge clk);
        insn = w; streaming_mode = strm; stream_cap_en = cap;
        src_vec = s; pred = p; in_valid = 1'b1;
        #1;
        check_vec({tag, " R8 dec_pg"}, VLEN'(dec_pg), VLEN'(w[12:10]));
        check_vec({tag, " R8 dec_zn"}, VLEN'(dec_zn), VLEN'(w[9:5]));
        ok      = (w[31:24] == 8'h05) && (w[21:13] == 9'b110001100) && !(strm && !cap);
        exp_d   = ok ? ref_expand(s, p, w[23:22]) : '0;
        exp_dst = ok ? w[4:0] : 5'd0;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({tag, " R7/R8 valid"}, res_valid, ok);
        check_bit({tag, " R5/R6 undef"}, res_undef, !ok);
        check_vec({tag, " R8 dst"}, VLEN'(res_dst), VLEN'(exp_dst));
        check_vec({tag, " R3/R4 data"}, res_data, exp_d);
        last_data = exp_d;
        last_dst  = exp_dst;
    endtask

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VLEN-1:0] s;
        void'($urandom(32'h5eed));
        rst = 1'b1; in_valid = 1'b0; insn = '0; streaming_mode = 1'b0;
        stream_cap_en = 1'b0; src_vec = '0; pred = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check_bit("R9 valid", res_valid, 1'b0);
        check_bit("R9 undef", res_undef, 1'b0);
        check_vec("R9 data", res_data, '0);
        check_vec("R9 dst", VLEN'(res_dst), '0);

        s = rnd_vec();
        // R4 empty predicate, every size
        for (int z = 0; z < 4; z++)
            run_vec("R4 empty", mk_insn(2'(z), 3'd1, 5'd2, 5'd3), 1'b0, 1'b0, s, '0);
        // R1 R3 full predicate, every size gives the source unchanged
        for (int z = 0; z < 4; z++)
            run_vec("R1 full", mk_insn(2'(z), 3'd7, 5'd31, 5'd17), 1'b0, 1'b0, s, '1);
        // R2 only non-leading bits set: wider elements see no active lane
        for (int z = 1; z < 4; z++)
            run_vec("R2 ignored", mk_insn(2'(z), 3'd0, 5'd0, 5'd9), 1'b0, 1'b0, s,
                    {(NB/2){2'b10}});
        // R2 leading bit of last dword lane only
        run_vec("R2 last lane", mk_insn(2'd3, 3'd2, 5'd4, 5'd5), 1'b0, 1'b0, s,
                NB'(1) << (NB - 8));

        // R10 idle cycle keeps data, drops strobes
        @(negedge clk);
        check_bit("R10 valid idle", res_valid, 1'b0);
        check_bit("R10 undef idle", res_undef, 1'b0);
        check_vec("R10 data held", res_data, last_data);
        check_vec("R10 dst held", VLEN'(res_dst), VLEN'(last_dst));

        // R5 opcode corruption
        run_vec("R5 top", mk_insn(2'd0, 3'd1, 5'd1, 5'd1) ^ 32'h0100_0000, 1'b0, 1'b0, s, '1);
        run_vec("R5 mid", mk_insn(2'd2, 3'd1, 5'd1, 5'd1) ^ 32'h0000_2000, 1'b0, 1'b0, s, '1);
        run_vec("R5 mid hi", mk_insn(2'd1, 3'd1, 5'd1, 5'd1) ^ 32'h0020_0000, 1'b0, 1'b0, s, '1);
        // R6 mode and capability combinations
        for (int m = 0; m < 4; m++)
            run_vec("R6 mode", mk_insn(2'd1, 3'd3, 5'd6, 5'd12), m[0], m[1], s, rnd_vec()[NB-1:0]);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w;
            logic [NB-1:0] p;
            w = mk_insn(2'($urandom_range(0, 3)), 3'($urandom), 5'($urandom), 5'($urandom));
            if ($urandom_range(0, 15) == 0) w = w ^ (32'd1 << $urandom_range(13, 31));
            p = NB'($urandom);
            if ($urandom_range(0, 1) == 1) p = p & NB'($urandom);
            run_vec("R3 random", w, ($urandom_range(0, 7) == 0), $urandom_range(0, 1) == 1,
                    rnd_vec(), p);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule